// File: doc/BRIEF.md
# Vector Length Configuration Unit

This block executes the instruction that configures vector length for a vector extension that runs over the ordinary scalar register file. It holds two architectural values: the maximum vector length (MVL), which says how many consecutive scalar registers a vector operation may span, and the current vector length (VL), which says how many elements the next vector operations actually process. Both values range from 0 to 64, and both reset to 1, where a vector operation behaves exactly like a scalar one.

Each accepted 32-bit instruction word is decoded with bit 0 as the most significant bit. A new VL is taken from one of three places: a 6-bit immediate stored minus one, a general-purpose register read through a dedicated read port, or the value already held. MVL is either reloaded from the same immediate or kept. VL is then limited to MVL, and both registers are updated together. The result is returned as a single beat. That beat carries the final VL and MVL, an optional write of VL into a destination register, an optional update of condition field 0, and a flag for an illegal encoding.

The input and output use valid/ready. An input word is consumed when `in_valid` and `in_ready` are both high on a rising edge. `in_ready` is high whenever no result is pending, or when the pending result is being taken in the same cycle. A result stays on the output, unchanged, until `out_ready` is high.

Top module: `vlcfg_unit`

## Requirements
- R1: A word is decoded only if bits 0–5 (word[31:26]) equal the primary opcode parameter (default 19) and bits 26–30 (word[5:1]) equal the extended opcode parameter (default 27). Any other consumed word produces no result beat and leaves VL and MVL unchanged.
- R2: If reserved bit 22 (word[9]) or bit 23 (word[8]) is set in a matching word, the result beat has `out_illegal`=1, no register write and no condition update, and it reports VL and MVL unchanged. Both held registers also keep their values.
- R3: The immediate field, bits 16–21 (word[15:10]), decodes to the field value plus one, so encoded 0 gives 1 and encoded 63 gives 64.
- R4: vs is bit 24 (word[7]) and RA is bits 11–15 (word[20:16]). The VL candidate is the register value when vs=1 and RA≠0, the decoded immediate when vs=1 and RA=0, and the held VL when vs=0.
- R5: ms is bit 25 (word[6]). The new MVL is the decoded immediate when ms=1 and the held MVL when ms=0.
- R6: The final VL is min(candidate, new MVL), with the register value read as unsigned 64-bit. Both held registers take the final values, so lowering MVL also lowers the held VL.
- R7: RT is bits 6–10 (word[25:21]). When RT≠0, the beat requests a write of the final VL, zero-extended, to register RT. When RT=0, no write is requested.
- R8: Rc is bit 31 (word[0]). When Rc=1, condition field 0 is written as {lt,gt,eq,so} = {0, VL>0, VL==0, `so_in`}, using the final VL. When Rc=0, no condition write is requested.
- R9: After reset, VL=MVL=1, `out_valid`=0 and `in_ready`=1.
- R10: The result of a consumed word appears on the first rising edge after it is consumed. A result with `out_ready` low holds stable, and `in_ready` stays low until that result is taken.
- R11: `gpr_rd_addr` equals the RA field of `in_instr` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction word valid |
| in_ready | output | 1 | Block can consume a word |
| in_instr | input | 32 | Instruction word |
| gpr_rd_addr | output | 5 | Register read address (RA field) |
| gpr_rd_data | input | XLEN | Register read data, same cycle |
| so_in | input | 1 | Summary-overflow bit copied into CR0 |
| out_valid | output | 1 | Result beat valid |
| out_ready | input | 1 | Consumer takes the result |
| out_illegal | output | 1 | Reserved bits were set |
| out_vl | output | 7 | Final VL |
| out_mvl | output | 7 | Final MVL |
| out_gpr_we | output | 1 | Register write request |
| out_gpr_addr | output | 5 | Register write address |
| out_gpr_data | output | XLEN | Register write data |
| out_cr_we | output | 1 | Condition field 0 write request |
| out_cr0 | output | 4 | {lt,gt,eq,so} |
| cur_vl | output | 7 | Held VL |
| cur_mvl | output | 7 | Held MVL |

## Verification
The register read address depends only on logic, so it is sampled in the same cycle the word is driven. Every other result, including the held VL and MVL, is registered on the edge that consumes the word. The bench therefore drives each word half a cycle before that edge and samples every output half a cycle after it. For the back-pressure case, the bench samples on each following falling edge, and during those cycles both the held result and the held registers must not move.

// File: rtl/vlcfg_pkg.sv
package vlcfg_pkg;
  localparam int INSTR_W = 32;
  localparam int REG_W   = 5;
  localparam int IMM_W   = 6;
  localparam int VLW     = IMM_W + 1;   // holds 0..64
  localparam int PO_W    = 6;
  localparam int XO_W    = 5;

  typedef struct packed {
    logic [PO_W-1:0]  po;
    logic [REG_W-1:0] rt;
    logic [REG_W-1:0] ra;
    logic [IMM_W-1:0] imm;
    logic             rsv_a;
    logic             rsv_b;
    logic             vs;
    logic             ms;
    logic [XO_W-1:0]  xo;
    logic             rc;
  } vlcfg_fields_t;
endpackage

// File: rtl/vlcfg_decode.sv
module vlcfg_decode
  import vlcfg_pkg::*;
#(
  parameter logic [PO_W-1:0] PO_MATCH = 6'd19,
  parameter logic [XO_W-1:0] XO_MATCH = 5'd27
) (
  input  logic [INSTR_W-1:0] instr,
  output vlcfg_fields_t      fld,
  output logic               hit,
  output logic               rsv_bad
);
  // bit k in MSB-0 numbering is instr[INSTR_W-1-k]
  always_comb begin
    fld.po    = instr[31:26];
    fld.rt    = instr[25:21];
    fld.ra    = instr[20:16];
    fld.imm   = instr[15:10];
    fld.rsv_a = instr[9];
    fld.rsv_b = instr[8];
    fld.vs    = instr[7];
    fld.ms    = instr[6];
    fld.xo    = instr[5:1];
    fld.rc    = instr[0];
  end

  assign hit     = (fld.po == PO_MATCH) && (fld.xo == XO_MATCH);
  assign rsv_bad = fld.rsv_a | fld.rsv_b;
endmodule

// File: rtl/vlcfg_select.sv
module vlcfg_select
  import vlcfg_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  vlcfg_fields_t   fld,
  input  logic [XLEN-1:0] gpr_val,
  input  logic [VLW-1:0]  vl_q,
  input  logic [VLW-1:0]  mvl_q,
  output logic [VLW-1:0]  new_vl,
  output logic [VLW-1:0]  new_mvl
);
  logic [VLW-1:0]  imm_val;
  logic [XLEN-1:0] cand;

  assign imm_val = VLW'(fld.imm) + VLW'(1);
  assign new_mvl = fld.ms ? imm_val : mvl_q;

  always_comb begin
    if (fld.vs && (fld.ra != '0)) cand = gpr_val;
    else if (fld.vs)              cand = XLEN'(imm_val);
    else                          cand = XLEN'(vl_q);
  end

  assign new_vl = (cand >= XLEN'(new_mvl)) ? new_mvl : cand[VLW-1:0];
endmodule

// File: rtl/vlcfg_commit.sv
module vlcfg_commit
  import vlcfg_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic              hit,
  input  logic              rsv_bad,
  input  vlcfg_fields_t     fld,
  input  logic [VLW-1:0]    new_vl,
  input  logic [VLW-1:0]    new_mvl,
  input  logic              so_in,
  input  logic              out_ready,
  output logic              out_valid,
  output logic              out_illegal,
  output logic [VLW-1:0]    out_vl,
  output logic [VLW-1:0]    out_mvl,
  output logic              out_gpr_we,
  output logic [REG_W-1:0]  out_gpr_addr,
  output logic [XLEN-1:0]   out_gpr_data,
  output logic              out_cr_we,
  output logic [3:0]        out_cr0,
  output logic [VLW-1:0]    vl_q,
  output logic [VLW-1:0]    mvl_q
);
  logic go, good;
  assign go   = take && hit;
  assign good = go && !rsv_bad;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vl_q         <= VLW'(1);
      mvl_q        <= VLW'(1);
      out_valid    <= 1'b0;
      out_illegal  <= 1'b0;
      out_vl       <= '0;
      out_mvl      <= '0;
      out_gpr_we   <= 1'b0;
      out_gpr_addr <= '0;
      out_gpr_data <= '0;
      out_cr_we    <= 1'b0;
      out_cr0      <= '0;
    end else begin
      if (out_valid && out_ready) out_valid <= 1'b0;
      if (go) begin
        out_valid    <= 1'b1;
        out_illegal  <= rsv_bad;
        out_vl       <= rsv_bad ? vl_q  : new_vl;
        out_mvl      <= rsv_bad ? mvl_q : new_mvl;
        out_gpr_we   <= !rsv_bad && (fld.rt != '0);
        out_gpr_addr <= fld.rt;
        out_gpr_data <= XLEN'(new_vl);
        out_cr_we    <= !rsv_bad && fld.rc;
        out_cr0      <= {1'b0, (new_vl != '0), (new_vl == '0), so_in};
      end
      if (good) begin
        vl_q  <= new_vl;
        mvl_q <= new_mvl;
      end
    end
  end

  // R6
  vl_within_mvl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vl_q <= mvl_q);

  // R2
  illegal_keeps_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (go && rsv_bad) |=> ($stable(vl_q) && $stable(mvl_q)));

  // R2
  illegal_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_illegal) |-> (!out_gpr_we && !out_cr_we));

  // R1
  ignored_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !hit) |=> (!out_valid && $stable(vl_q) && $stable(mvl_q)));

  // R10
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_vl) && $stable(out_gpr_data)
                                   && $stable(out_cr0)));

  // R8
  cr_eq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_cr_we) |-> (out_cr0[1] == (out_vl == '0)) && !out_cr0[3]);

  // R7
  rt_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_gpr_we) |-> (out_gpr_addr != '0));

  // R6
  result_matches_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_illegal) |-> (out_vl == vl_q && out_mvl == mvl_q));
endmodule

// File: rtl/vlcfg_unit.sv
module vlcfg_unit
  import vlcfg_pkg::*;
#(
  parameter int              XLEN     = 64,
  parameter logic [PO_W-1:0] PO_MATCH = 6'd19,
  parameter logic [XO_W-1:0] XO_MATCH = 5'd27
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [INSTR_W-1:0]   in_instr,
  output logic [REG_W-1:0]     gpr_rd_addr,
  input  logic [XLEN-1:0]      gpr_rd_data,
  input  logic                 so_in,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic                 out_illegal,
  output logic [VLW-1:0]       out_vl,
  output logic [VLW-1:0]       out_mvl,
  output logic                 out_gpr_we,
  output logic [REG_W-1:0]     out_gpr_addr,
  output logic [XLEN-1:0]      out_gpr_data,
  output logic                 out_cr_we,
  output logic [3:0]           out_cr0,
  output logic [VLW-1:0]       cur_vl,
  output logic [VLW-1:0]       cur_mvl
);
  vlcfg_fields_t  fld;
  logic           hit, rsv_bad, take;
  logic [VLW-1:0] new_vl, new_mvl, vl_q, mvl_q;

  assign in_ready    = !out_valid || out_ready;
  assign take        = in_valid && in_ready;
  assign gpr_rd_addr = fld.ra;
  assign cur_vl      = vl_q;
  assign cur_mvl     = mvl_q;

  vlcfg_decode #(.PO_MATCH(PO_MATCH), .XO_MATCH(XO_MATCH)) u_dec (
    .instr(in_instr), .fld(fld), .hit(hit), .rsv_bad(rsv_bad));

  vlcfg_select #(.XLEN(XLEN)) u_sel (
    .fld(fld), .gpr_val(gpr_rd_data), .vl_q(vl_q), .mvl_q(mvl_q),
    .new_vl(new_vl), .new_mvl(new_mvl));

  vlcfg_commit #(.XLEN(XLEN)) u_cmt (
    .clk(clk), .rst_n(rst_n), .take(take), .hit(hit), .rsv_bad(rsv_bad),
    .fld(fld), .new_vl(new_vl), .new_mvl(new_mvl), .so_in(so_in),
    .out_ready(out_ready), .out_valid(out_valid), .out_illegal(out_illegal),
    .out_vl(out_vl), .out_mvl(out_mvl), .out_gpr_we(out_gpr_we),
    .out_gpr_addr(out_gpr_addr), .out_gpr_data(out_gpr_data),
    .out_cr_we(out_cr_we), .out_cr0(out_cr0), .vl_q(vl_q), .mvl_q(mvl_q));

  // R10
  ready_after_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready) |-> in_ready);
endmodule

// File: tb/vlcfg_unit_test.sv
module vlcfg_unit_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_instr = '0;
  logic [4:0]  gpr_rd_addr;
  logic [63:0] gpr_rd_data = '0;
  logic        so_in = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic        out_illegal;
  logic [6:0]  out_vl, out_mvl, cur_vl, cur_mvl;
  logic        out_gpr_we, out_cr_we;
  logic [4:0]  out_gpr_addr;
  logic [63:0] out_gpr_data;
  logic [3:0]  out_cr0;

  int checks = 0;
  int errors = 0;
  int m_vl = 1;
  int m_mvl = 1;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vlcfg_unit uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_instr(in_instr), .gpr_rd_addr(gpr_rd_addr), .gpr_rd_data(gpr_rd_data),
    .so_in(so_in), .out_valid(out_valid), .out_ready(out_ready),
    .out_illegal(out_illegal), .out_vl(out_vl), .out_mvl(out_mvl),
    .out_gpr_we(out_gpr_we), .out_gpr_addr(out_gpr_addr),
    .out_gpr_data(out_gpr_data), .out_cr_we(out_cr_we), .out_cr0(out_cr0),
    .cur_vl(cur_vl), .cur_mvl(cur_mvl));

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] word(input int rt, input int ra, input int imm,
      input bit ra22, input bit ra23, input bit vs, input bit ms, input bit rc,
      input int po = 19, input int xo = 27);
    logic [31:0] w;
    w[31:26] = po[5:0]; w[25:21] = rt[4:0]; w[20:16] = ra[4:0];
    w[15:10] = imm[5:0]; w[9] = ra22; w[8] = ra23; w[7] = vs; w[6] = ms;
    w[5:1] = xo[4:0]; w[0] = rc;
    return w;
  endfunction

  task automatic drive(input logic [31:0] w, input logic [63:0] g, input bit so);
    @(negedge clk);
    in_instr = w; in_valid = 1'b1; gpr_rd_data = g; so_in = so;
    #1;
    check("R11 read address", 64'(gpr_rd_addr), 64'(w[20:16]));
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic run(input int rt, input int ra, input int imm, input bit vs,
                     input bit ms, input bit rc, input logic [63:0] g, input bit so);
    int immv, nm, nv;
    logic [63:0] cand;
    immv = imm + 1;
    nm = ms ? immv : m_mvl;
    if (vs && ra != 0) cand = g;
    else if (vs) cand = 64'(immv);
    else cand = 64'(m_vl);
    nv = (cand >= 64'(nm)) ? nm : int'(cand);
    m_vl = nv; m_mvl = nm;
    drive(word(rt, ra, imm, 0, 0, vs, ms, rc), g, so);
    check("R10 result valid", 64'(out_valid), 1);
    check("R2 not illegal", 64'(out_illegal), 0);
    check("R6 out VL", 64'(out_vl), 64'(nv));
    check("R5 out MVL", 64'(out_mvl), 64'(nm));
    check("R6 held VL", 64'(cur_vl), 64'(nv));
    check("R5 held MVL", 64'(cur_mvl), 64'(nm));
    check("R7 write enable", 64'(out_gpr_we), 64'(rt != 0));
    if (rt != 0) begin
      check("R7 write addr", 64'(out_gpr_addr), 64'(rt));
      check("R7 write data", out_gpr_data, 64'(nv));
    end
    check("R8 cr enable", 64'(out_cr_we), 64'(rc));
    if (rc) check("R8 cr0 bits", 64'(out_cr0), 64'({1'b0, nv > 0, nv == 0, so}));
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [63:0] gv [9];
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    check("R9 VL reset", 64'(cur_vl), 1);
    check("R9 MVL reset", 64'(cur_mvl), 1);
    check("R9 out_valid reset", 64'(out_valid), 0);
    check("R9 in_ready reset", 64'(in_ready), 1);

    // R3 every immediate code, VL and MVL together
    for (int i = 0; i < 64; i++) run(i % 32, 0, i, 1, 1, i % 2, 64'hDEAD, i % 3 == 0);

    // R4 R6 register source against many MVL settings
    for (int e = 0; e < 64; e += 5) begin
      run(0, 0, e, 0, 1, 0, 0, 0);
      gv[0] = 0; gv[1] = 1; gv[2] = 64'(e); gv[3] = 64'(e + 1); gv[4] = 64'(e + 2);
      gv[5] = 64; gv[6] = 65; gv[7] = 64'h8000_0000_0000_0000; gv[8] = '1;
      for (int k = 0; k < 9; k++) run(3, 7, 0, 1, 0, 1, gv[k], k % 2);
    end

    // R4 held VL kept, read-only form
    run(0, 0, 39, 0, 1, 0, 0, 0);
    run(0, 4, 0, 1, 0, 0, 64'd20, 0);
    run(9, 0, 0, 0, 0, 1, 64'd5, 1);
    // R6 lowering MVL lowers held VL
    run(0, 0, 7, 0, 1, 1, 0, 0);
    // R4 immediate source clamped to MVL
    run(2, 0, 50, 1, 0, 1, 0, 0);
    // R8 zero VL from register
    run(0, 0, 63, 0, 1, 0, 0, 0);
    run(31, 6, 0, 1, 0, 1, 64'd0, 1);

    // R2 reserved bits
    for (int b = 0; b < 2; b++) begin
      drive(word(5, 0, 10, b == 0, b == 1, 1, 1, 1), 0, 0);
      check("R2 valid", 64'(out_valid), 1);
      check("R2 illegal", 64'(out_illegal), 1);
      check("R2 no gpr write", 64'(out_gpr_we), 0);
      check("R2 no cr write", 64'(out_cr_we), 0);
      check("R2 VL kept", 64'(cur_vl), 64'(m_vl));
      check("R2 MVL kept", 64'(cur_mvl), 64'(m_mvl));
      check("R2 reported VL", 64'(out_vl), 64'(m_vl));
    end

    // R1 mismatching opcodes
    drive(word(5, 0, 20, 0, 0, 1, 1, 1, 18, 27), 0, 0);
    check("R1 bad primary no beat", 64'(out_valid), 0);
    check("R1 bad primary VL", 64'(cur_vl), 64'(m_vl));
    drive(word(5, 0, 20, 0, 0, 1, 1, 1, 19, 26), 0, 0);
    check("R1 bad extended no beat", 64'(out_valid), 0);
    check("R1 bad extended MVL", 64'(cur_mvl), 64'(m_mvl));

    // R10 back-pressure
    out_ready = 1'b0;
    run(4, 0, 11, 1, 1, 0, 0, 0);   // A: VL=MVL=12
    in_instr = word(6, 0, 2, 0, 0, 1, 0, 0);   // B: VL=3
    in_valid = 1'b1;
    #1;
    check("R10 in_ready low while stalled", 64'(in_ready), 0);
    @(negedge clk);
    check("R10 held valid", 64'(out_valid), 1);
    check("R10 held VL", 64'(out_vl), 12);
    check("R10 held addr", 64'(out_gpr_addr), 4);
    check("R10 B not consumed", 64'(cur_vl), 12);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    m_vl = 3;
    check("R10 B result valid", 64'(out_valid), 1);
    check("R10 B VL", 64'(out_vl), 3);
    check("R10 B addr", 64'(out_gpr_addr), 6);
    @(negedge clk);
    check("R10 drained", 64'(out_valid), 0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule